// File: doc/BRIEF.md
# Shared Interrupt Request Combiner

This block sits on an expansion card that carries two independent I/O functions and only one interrupt request pin toward the host. Each function raises a level-sensitive request; the block synchronizes it, decides whether it may reach the card pin, and drives one shared interrupt line. A small register port lets host software program, for each function, an option register (enable, address-decode enable, interrupt routing enable and three vendor bits) and a status register (interrupt mode select and a pending flag).

Each function runs in one of two modes. In legacy mode the shared line simply follows the routed request of the function, as a card with a single function would, and drops as soon as the function withdraws it. In acknowledgment mode the card produces exactly one rising edge per notification and holds the line until the host writes 0 to the pending flag. The line then goes low for at least one clock and rises again if any routed acknowledgment-mode function still needs service. An edge-triggered interrupt controller therefore never misses a second event. The pending flag reads the same combined value through every function's status register.

Top module: `irqc_shared_combiner`

## Requirements
- R1: After reset every option and status register reads 0x00 and `card_irq` is low.
- R2: Register address bit 0 selects option (0) or status (1), the upper address bits select the function; option bits 5:0 are stored and read back as written (bit 0 function enable, bit 1 decode enable, bit 2 routing enable, bits 5:3 vendor), option bits 7:6 read 0.
- R3: A legacy-mode function (status bit 0 = 0) whose request is routed drives `card_irq` high within three clocks of its input rising and releases it within three clocks of the input falling.
- R4: When a routed acknowledgment-mode function (status bit 0 = 1) requests, `card_irq` rises once and stays high, with no further rising edge, until acknowledged, even if the request input drops.
- R5: An acknowledgment is a status write with data bit 1 = 0 to a function whose current mode bit is 1; `card_irq` is low in the clock after it, and a status write with data bit 1 = 1 does not acknowledge.
- R6: If any routed acknowledgment-mode request is still present when acknowledged, `card_irq` is low for exactly one clock and then rises again.
- R7: A function contributes to `card_irq` only when both option bit 0 and option bit 2 are 1, in either mode.
- R8: Status bit 0 reads the function's mode, status bit 1 reads the current level of `card_irq` for every function alike, and status bits 7:2 read 0.
- R9: A status write to a legacy-mode function has no effect on `card_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_irq | input | NUM_FUNC | Level interrupt request from each function, asynchronous |
| reg_cs | input | 1 | Register access select |
| reg_we | input | 1 | Write strobe (1 = write, 0 = read) |
| reg_addr | input | $clog2(NUM_FUNC)+1 | Bit 0 register select, upper bits function select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while selected for read |
| card_irq | output | 1 | Shared card interrupt request line, active high |

## Verification
The hardest situation to reach is an acknowledgment that lands while another acknowledgment-mode function is still requesting, since the one-clock gap and the re-assertion only appear then. The stimulus raises both function inputs together, waits for the single held edge, acknowledges through the second function's status register and samples the line in the two clocks that follow, while a bench-side edge counter confirms exactly one extra rising edge. Writes that must not acknowledge (pending bit written as 1, writes to a legacy-mode function) are placed while the line is held, so any wrong release shows at the pin.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int REG_W = 8;

  // option register layout: bit0 function enable, bit1 decode enable,
  // bit2 routing enable, bits5:3 vendor storage
  typedef struct packed {
    logic [2:0] vendor;
    logic       route_en;
    logic       decode_en;
    logic       func_en;
  } opt_t;

  localparam int OPT_W = $bits(opt_t);

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_HELD = 2'd1,
    ACK_GAP  = 2'd2
  } ack_state_e;

  function automatic logic is_routed(opt_t o);
    return o.func_en & o.route_en;
  endfunction

  function automatic logic [REG_W-1:0] pack_option(opt_t o);
    return {{(REG_W-OPT_W){1'b0}}, o};
  endfunction

  function automatic logic [REG_W-1:0] pack_status(logic mode, logic pend);
    return {{(REG_W-2){1'b0}}, pend, mode};
  endfunction

  function automatic logic is_ack_write(logic wr_sts, logic cur_mode,
                                        logic [REG_W-1:0] wdata);
    return wr_sts & cur_mode & ~wdata[1];
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_func_regs.sv
module irqc_func_regs
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_opt,
  input  logic             wr_sts,
  input  logic [REG_W-1:0] wdata,
  output opt_t             opt_q,
  output logic             mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (wr_opt) opt_q  <= opt_t'(wdata[OPT_W-1:0]);
      if (wr_sts) mode_q <= wdata[0];
    end
  end

  // R2: option storage only changes on a write to it
  a_r2_opt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_opt |=> $stable(opt_q));

  // R8: mode bit only changes on a status write
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sts |=> $stable(mode_q));
endmodule

// File: rtl/irqc_ack_fsm.sv
module irqc_ack_fsm
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_req,
  input  logic       ack,
  output logic       line,
  output ack_state_e state
);
  ack_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACK_IDLE: if (any_req) state_d = ACK_HELD;
      ACK_HELD: if (ack)     state_d = ACK_GAP;
      ACK_GAP:  state_d = any_req ? ACK_HELD : ACK_IDLE;
      default:  state_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACK_IDLE;
    else        state_q <= state_d;
  end

  assign line  = (state_q == ACK_HELD);
  assign state = state_q;

  // R4: held line stays up until acknowledged
  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (line && !ack) |=> line);

  // R5: acknowledgment drops the line in the next clock
  a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (line && ack) |=> !line);

  // R6: a remaining request after the gap re-asserts the line
  a_r6_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ACK_GAP && any_req) |=> line);

  // R6: with nothing requesting the idle machine stays low
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ACK_IDLE && !any_req) |=> !line);
endmodule

// File: rtl/irqc_shared_combiner.sv
module irqc_shared_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_FUNC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_FUNC-1:0]           func_irq,
  input  logic                          reg_cs,
  input  logic                          reg_we,
  input  logic [$clog2(NUM_FUNC):0]     reg_addr,
  input  logic [7:0]                    reg_wdata,
  output logic [7:0]                    reg_rdata,
  output logic                          card_irq
);
  localparam int FSEL_W = $clog2(NUM_FUNC);
  localparam int ADDR_W = FSEL_W + 1;

  logic [FSEL_W-1:0]   fsel;
  logic                sel_sts;
  logic [NUM_FUNC-1:0] irq_sync;
  logic [NUM_FUNC-1:0] wr_opt, wr_sts;
  logic [NUM_FUNC-1:0] mode_vec;
  logic [NUM_FUNC-1:0] routed_vec;
  logic [NUM_FUNC-1:0] legacy_req;
  logic [NUM_FUNC-1:0] ackmode_req;
  opt_t                opt_arr [NUM_FUNC];

  // named internal events for assertions
  logic       legacy_any;
  logic       ackmode_any;
  logic       ack_strobe;
  logic       held_line;
  ack_state_e ack_state;

  assign fsel    = reg_addr[ADDR_W-1:1];
  assign sel_sts = reg_addr[0];

  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
    logic hit;
    assign hit = (fsel == FSEL_W'(f));

    irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(func_irq[f]),
      .q_sync (irq_sync[f])
    );

    assign wr_opt[f] = reg_cs & reg_we & hit & ~sel_sts;
    assign wr_sts[f] = reg_cs & reg_we & hit &  sel_sts;

    irqc_func_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_opt(wr_opt[f]),
      .wr_sts(wr_sts[f]),
      .wdata (reg_wdata),
      .opt_q (opt_arr[f]),
      .mode_q(mode_vec[f])
    );

    assign routed_vec[f]  = is_routed(opt_arr[f]);
    assign legacy_req[f]  = irq_sync[f] & routed_vec[f] & ~mode_vec[f];
    assign ackmode_req[f] = irq_sync[f] & routed_vec[f] &  mode_vec[f];
  end

  assign legacy_any  = |legacy_req;
  assign ackmode_any = |ackmode_req;

  always_comb begin
    ack_strobe = 1'b0;
    for (int f = 0; f < NUM_FUNC; f++) begin
      if (is_ack_write(wr_sts[f], mode_vec[f], reg_wdata)) ack_strobe = 1'b1;
    end
  end

  irqc_ack_fsm u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .any_req(ackmode_any),
    .ack    (ack_strobe),
    .line   (held_line),
    .state  (ack_state)
  );

  assign card_irq = legacy_any | held_line;

  always_comb begin
    reg_rdata = '0;
    for (int f = 0; f < NUM_FUNC; f++) begin
      if (reg_cs && !reg_we && fsel == FSEL_W'(f)) begin
        reg_rdata = sel_sts ? pack_status(mode_vec[f], card_irq)
                            : pack_option(opt_arr[f]);
      end
    end
  end

  // R7: with no routed function and no held notification the pin is quiet
  a_r7_unrouted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(routed_vec) == 0 && ack_state != ACK_HELD) |-> !card_irq);

  // R9: a status write to a legacy-mode function never acknowledges
  a_r9_legacy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(wr_sts) && (wr_sts & mode_vec) == '0) |-> !ack_strobe);
endmodule

// File: tb/irqc_shared_combiner_tb.sv
module irqc_shared_combiner_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] func_irq = '0;
  logic       reg_cs = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       card_irq;

  int checks = 0;
  int bad = 0;
  int edges = 0;
  logic prev_irq = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;  // 125 MHz

  irqc_shared_combiner #(.NUM_FUNC(2), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .func_irq(func_irq),
    .reg_cs(reg_cs), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_irq(card_irq)
  );

  // rising edge counter on the shared line
  always @(negedge clk) begin
    if (!rst_n) prev_irq <= 1'b0;
    else begin
      if (card_irq && !prev_irq) edges <= edges + 1;
      prev_irq <= card_irq;
    end
  end

  // scoreboard monitor for register reads
  always @(negedge clk) begin
    if (rst_n && reg_cs && !reg_we) begin
      if (exp_q.size() == 0) begin
        checks++; bad++;
        $display("FAIL read with no expected item, got %02h", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (reg_rdata !== e) begin
          bad++;
          $display("FAIL %s: rdata=%02h expected=%02h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_cs = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(posedge clk); #1;
    reg_cs = 1'b0;
  endtask

  task automatic chk_line(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (card_irq !== e) begin
      bad++;
      $display("FAIL %s: card_irq=%0b expected=%0b", t, card_irq, e);
    end
    @(posedge clk); #1;
  endtask

  task automatic chk_edges(input int e, input string t);
    checks++;
    if (edges != e) begin
      bad++;
      $display("FAIL %s: edges=%0d expected=%0d", t, edges, e);
    end
  endtask

  initial begin : watchdog
    #(8 * 20000);
    checks++; bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : stim
    int e0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(2'd0, 8'h00, "R1 f0 option");
    rd(2'd1, 8'h00, "R1 f0 status");
    rd(2'd2, 8'h00, "R1 f1 option");
    rd(2'd3, 8'h00, "R1 f1 status");
    chk_line(1'b0, "R1 line after reset");

    // R7 unrouted request, then enable without routing
    func_irq[0] = 1'b1;
    tick(5);
    chk_line(1'b0, "R7 unconfigured request");
    wr(2'd0, 8'h01);
    tick(4);
    chk_line(1'b0, "R7 enabled but not routed");

    // R3 legacy mode
    wr(2'd0, 8'h05);
    chk_line(1'b1, "R3 legacy routed request");
    rd(2'd1, 8'h02, "R8 f0 pending");
    rd(2'd3, 8'h02, "R8 f1 aliased pending");
    func_irq[0] = 1'b0;
    tick(3);
    chk_line(1'b0, "R3 legacy release");
    rd(2'd1, 8'h00, "R8 pending cleared");

    // R2 option storage
    wr(2'd2, 8'h3F);
    rd(2'd2, 8'h3F, "R2 vendor and enables");
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h3F, "R2 upper bits read zero");
    wr(2'd2, 8'h05);
    rd(2'd0, 8'h05, "R2 f0 option unaffected");

    // R4 acknowledgment mode hold
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h01);
    rd(2'd1, 8'h01, "R8 mode bit");
    e0 = edges;
    func_irq[0] = 1'b1;
    tick(4);
    chk_line(1'b1, "R4 notification raised");
    tick(10);
    chk_line(1'b1, "R4 still held");
    chk_edges(e0 + 1, "R4 single edge");
    func_irq[0] = 1'b0;
    tick(4);
    chk_line(1'b1, "R4 held after input drop");

    // R5 acknowledgment rules
    wr(2'd1, 8'h03);
    chk_line(1'b1, "R5 pending written 1 ignored");
    rd(2'd3, 8'h03, "R8 f1 aliased held pending");
    wr(2'd1, 8'h01);
    chk_line(1'b0, "R5 ack drops line");
    tick(3);
    chk_line(1'b0, "R5 stays low with nothing pending");

    // R6 re-assertion after ack
    e0 = edges;
    func_irq = 2'b11;
    tick(4);
    chk_line(1'b1, "R6 both requesting");
    wr(2'd3, 8'h01);
    @(negedge clk);
    checks++;
    if (card_irq !== 1'b0) begin
      bad++;
      $display("FAIL R6 gap clock: card_irq=%0b expected=0", card_irq);
    end
    @(negedge clk);
    checks++;
    if (card_irq !== 1'b1) begin
      bad++;
      $display("FAIL R6 re-assert: card_irq=%0b expected=1", card_irq);
    end
    @(posedge clk); #1;
    chk_edges(e0 + 2, "R6 fresh edge");
    func_irq = 2'b00;
    tick(4);
    wr(2'd1, 8'h01);
    tick(2);
    chk_line(1'b0, "R6 cleanup idle");

    // R7 in acknowledgment mode
    wr(2'd2, 8'h01);
    func_irq[1] = 1'b1;
    tick(5);
    chk_line(1'b0, "R7 ack mode unrouted");
    func_irq[1] = 1'b0;
    tick(3);
    wr(2'd2, 8'h05);

    // R9 status writes to a legacy function
    wr(2'd1, 8'h00);
    func_irq[0] = 1'b1;
    tick(4);
    chk_line(1'b1, "R3 legacy again");
    wr(2'd1, 8'h00);
    chk_line(1'b1, "R9 legacy status write 0");
    wr(2'd1, 8'h02);
    tick(2);
    chk_line(1'b1, "R9 legacy status write 1");
    func_irq[0] = 1'b0;
    tick(4);
    chk_line(1'b0, "R3 final release");

    tick(2);
    if (exp_q.size() != 0) begin
      checks++; bad++;
      $display("FAIL scoreboard: %0d reads left, expected 0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule